// File: doc/BRIEF.md
# DRAM Self-Refresh Entry and Exit Sequencer

This block takes a synchronous DRAM into its low-power self-refresh state when the system asks to power down, and brings it back out in a safe order. It sits beside the normal command scheduler. While it is active it owns the clock-enable pin and the command pins, and its `busy` output tells the surrounding logic to route the command bus from the sequencer.

Entry is a single cycle. The refresh command code is driven with clock enable low in that same cycle. Entry is accepted only when the scheduler reports that every bank is precharged and the precharge recovery time has elapsed. Until then the request waits. Once inside, clock enable stays low for at least a programmed number of cycles. A wake request that arrives earlier is held until that minimum stay is over.

On wake, the sequencer waits for a clock-stable indication before it raises clock enable. It then fills the exit recovery window with no-operation commands. The window is never shorter than two cycles. Finally it pulses a refresh-now request to the refresh scheduler, together with a done acknowledge, so that regular refreshes start again at once.

Top module: `sr_seq`

## Requirements
- R1: While reset is asserted and in the first cycle after it, `cke` is 1, the command pins carry NOP, and `busy`, `sleep_ack`, `wake_done` and `refresh_now` are 0.
- R2: Entry happens only in a cycle where `sleep_req` and `banks_idle` are both 1 and `wake_req` is 0. In any other case `cke` stays 1 and `busy` stays 0.
- R3: In the entry cycle, `cke` is 0 and the pins {cs_n,ras_n,cas_n,we_n} are 4'b0001 (refresh). From that cycle on, `sleep_ack` is 1 for as long as `cke` is 0. Every other cycle carries NOP, 4'b0111.
- R4: After entry, `cke` stays 0 for at least T_MIN_STAY consecutive cycles, counting the entry cycle. A `wake_req` raised before that point is held pending and is not lost.
- R5: `cke` returns to 1 only after `clk_stable` has been sampled 1 while a wake is pending. Without it, `cke` stays 0 for as long as needed.
- R6: Starting with the first cycle in which `cke` is 1 again, the pins carry NOP for max(T_XSR,2) cycles.
- R7: In the cycle right after that window, `refresh_now` and `wake_done` are 1 together for exactly one cycle. In the next cycle the block is idle.
- R8: `busy` is 1 from the entry cycle through the `wake_done` cycle, and 0 at all other times.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Synchronous active-low reset |
| sleep_req | input | 1 | Level request to enter self refresh |
| banks_idle | input | 1 | All banks are precharged and the precharge recovery time is met |
| wake_req | input | 1 | Level request to leave self refresh, held until `wake_done` |
| clk_stable | input | 1 | The clock to the DRAM is within its specified limits |
| cke | output | 1 | Clock enable to the DRAM |
| dram_cs_n | output | 1 | Chip select, active low |
| dram_ras_n | output | 1 | Row strobe, active low |
| dram_cas_n | output | 1 | Column strobe, active low |
| dram_we_n | output | 1 | Write enable, active low |
| busy | output | 1 | The sequencer owns the command bus |
| sleep_ack | output | 1 | The DRAM is in self refresh (clock enable low) |
| wake_done | output | 1 | One-cycle pulse when the exit completes |
| refresh_now | output | 1 | One-cycle request for an immediate auto refresh |

## Verification
The assertions check the timing rules on every cycle. They confirm that a falling `cke` carries the refresh code and follows idle banks with no wake pending. They confirm that `cke` cannot rise before the minimum stay and only rises after `clk_stable` was seen. They also confirm that only NOPs follow the rise for the whole recovery window, and that `refresh_now` lands exactly at the end of that window. Other behaviours only appear across a full scenario, so the bench covers them. These are the exact length of the low period for each combination of wake timing and clock-stable delay, a wake that is held pending through the minimum stay, an entry that stalls while banks are busy, and the return to idle with `busy` released.

// File: rtl/sr_pkg.sv
// Shared types for the self-refresh sequencer.
// Assumes the usual four active-low command pins of a synchronous DRAM.
package sr_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ENTER,
        ST_HOLD,
        ST_SLEEP,
        ST_WAKE,
        ST_EXIT,
        ST_DONE
    } sr_state_t;

    typedef enum logic [0:0] {
        OP_NOP,
        OP_REFRESH
    } sr_op_t;

    typedef struct packed {
        logic cs_n;
        logic ras_n;
        logic cas_n;
        logic we_n;
    } dram_pins_t;

endpackage

// File: rtl/sr_timer.sv
// Down counter shared by the residency and exit-recovery windows.
// Assumes load and dec are never asserted together with conflicting intent;
// load has priority. zero is high whenever the count is zero.
module sr_timer #(
    parameter int W = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] load_val,
    input  logic         dec,
    output logic         zero
);

    logic [W-1:0] count_q;

    // Load a new window length or count the current one down.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            count_q <= '0;
        end else if (load) begin
            count_q <= load_val;
        end else if (dec && (count_q != '0)) begin
            count_q <= count_q - 1'b1;
        end
    end

    // Flag the end of the window.
    always_comb begin
        zero = (count_q == '0);
    end

endmodule

// File: rtl/sr_cmd_enc.sv
// Maps the sequencer's abstract operation onto the DRAM command pins.
// Assumes chip select is always asserted when the sequencer drives the bus.
module sr_cmd_enc
    import sr_pkg::*;
(
    input  sr_op_t     op,
    output dram_pins_t pins
);

    // Select the pin pattern for the requested operation.
    always_comb begin
        unique case (op)
            OP_REFRESH: pins = '{cs_n: 1'b0, ras_n: 1'b0, cas_n: 1'b0, we_n: 1'b1};
            default:    pins = '{cs_n: 1'b0, ras_n: 1'b1, cas_n: 1'b1, we_n: 1'b1};
        endcase
    end

endmodule

// File: rtl/sr_seq.sv
// Self-refresh entry/exit sequencer.
// Enters self refresh with a refresh command and clock enable low, holds
// clock enable low for at least T_MIN_STAY cycles, waits for a stable clock
// before leaving, fills max(T_XSR,2) cycles with NOPs, then pulses a
// refresh request and a done acknowledge.
// Assumes T_MIN_STAY >= 2. Requests are levels that the requester holds
// until they are answered.
module sr_seq
    import sr_pkg::*;
#(
    parameter int T_MIN_STAY = 12,
    parameter int T_XSR      = 20
) (
    input  logic clk,
    input  logic rst_n,
    input  logic sleep_req,
    input  logic banks_idle,
    input  logic wake_req,
    input  logic clk_stable,
    output logic cke,
    output logic dram_cs_n,
    output logic dram_ras_n,
    output logic dram_cas_n,
    output logic dram_we_n,
    output logic busy,
    output logic sleep_ack,
    output logic wake_done,
    output logic refresh_now
);

    localparam int XSR_EFF = (T_XSR < 2) ? 2 : T_XSR;
    localparam int CMAX    = (T_MIN_STAY > XSR_EFF) ? T_MIN_STAY : XSR_EFF;
    localparam int CW      = $clog2(CMAX + 1);

    sr_state_t  state_q, state_d;
    sr_op_t     op;
    dram_pins_t pins;
    logic       tmr_load, tmr_dec, tmr_zero;
    logic [CW-1:0] tmr_val;

    // Advance the sequencer state.
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // Pick the next state from the requests and the window timer.
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:  if (sleep_req && banks_idle && !wake_req) state_d = ST_ENTER;
            ST_ENTER: state_d = ST_HOLD;
            ST_HOLD:  if (tmr_zero) state_d = ST_SLEEP;
            ST_SLEEP: if (wake_req) state_d = ST_WAKE;
            ST_WAKE:  if (clk_stable) state_d = ST_EXIT;
            ST_EXIT:  if (tmr_zero) state_d = ST_DONE;
            ST_DONE:  state_d = ST_IDLE;
            default:  state_d = ST_IDLE;
        endcase
    end

    // Load the residency window on entry and the recovery window on exit.
    always_comb begin
        tmr_load = 1'b0;
        tmr_val  = '0;
        if (state_q == ST_ENTER) begin
            tmr_load = 1'b1;
            tmr_val  = CW'(T_MIN_STAY - 2);
        end else if (state_q == ST_WAKE && clk_stable) begin
            tmr_load = 1'b1;
            tmr_val  = CW'(XSR_EFF - 1);
        end
        tmr_dec = (state_q == ST_HOLD) || (state_q == ST_EXIT);
    end

    sr_timer #(.W(CW)) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (tmr_load),
        .load_val (tmr_val),
        .dec      (tmr_dec),
        .zero     (tmr_zero)
    );

    // Choose the command for this cycle.
    always_comb begin
        op = (state_q == ST_ENTER) ? OP_REFRESH : OP_NOP;
    end

    sr_cmd_enc u_enc (
        .op   (op),
        .pins (pins)
    );

    // Drive the clock enable, pins and handshakes from the state.
    always_comb begin
        cke = !((state_q == ST_ENTER) || (state_q == ST_HOLD) ||
                (state_q == ST_SLEEP) || (state_q == ST_WAKE));
        dram_cs_n   = pins.cs_n;
        dram_ras_n  = pins.ras_n;
        dram_cas_n  = pins.cas_n;
        dram_we_n   = pins.we_n;
        busy        = (state_q != ST_IDLE);
        sleep_ack   = !cke;
        wake_done   = (state_q == ST_DONE);
        refresh_now = (state_q == ST_DONE);
    end

    // ---------------- checks ----------------
    int low_run, hi_run;

    // Count consecutive earlier cycles with clock enable low or high.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            low_run <= 0;
            hi_run  <= 0;
        end else begin
            low_run <= cke ? 0 : ((low_run > CMAX) ? low_run : low_run + 1);
            hi_run  <= !cke ? 0 : ((hi_run > CMAX) ? hi_run : hi_run + 1);
        end
    end

    a_r2_entry_gated: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(cke) |-> ($past(banks_idle) && $past(sleep_req) && !$past(wake_req)));

    a_r3_entry_refresh: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(cke) |-> ({dram_cs_n, dram_ras_n, dram_cas_n, dram_we_n} == 4'b0001 && sleep_ack));

    a_r4_min_stay: assert property (@(posedge clk) disable iff (!rst_n)
        (!cke && low_run < T_MIN_STAY - 1) |=> !cke);

    a_r5_clock_gate: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(cke) |-> ($past(clk_stable) && $past(wake_req)));

    a_r6_nop_window: assert property (@(posedge clk) disable iff (!rst_n)
        (cke && hi_run <= XSR_EFF) |-> ({dram_cs_n, dram_ras_n, dram_cas_n, dram_we_n} == 4'b0111));

    a_r7_refresh_timing: assert property (@(posedge clk) disable iff (!rst_n)
        refresh_now |-> (hi_run == XSR_EFF && wake_done && cke));

    a_r7_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        refresh_now |=> (!refresh_now && !busy));

endmodule

// File: tb/sim_sr_seq.sv
`timescale 1ns/1ps
module sim_sr_seq;

    localparam int MS = 5;
    localparam int XS = 1;
    localparam int XE = (XS < 2) ? 2 : XS;

    logic clk = 1'b0;
    logic rst_n, sleep_req, banks_idle, wake_req, clk_stable;
    logic cke, cs_n, ras_n, cas_n, we_n, busy, sleep_ack, wake_done, refresh_now;
    logic [3:0] pins;
    int vec = 0;
    int bad = 0;
    bit finished = 0;

    always #2 clk = ~clk;
    assign pins = {cs_n, ras_n, cas_n, we_n};

    sr_seq #(.T_MIN_STAY(MS), .T_XSR(XS)) u0 (
        .clk(clk), .rst_n(rst_n), .sleep_req(sleep_req), .banks_idle(banks_idle),
        .wake_req(wake_req), .clk_stable(clk_stable), .cke(cke),
        .dram_cs_n(cs_n), .dram_ras_n(ras_n), .dram_cas_n(cas_n), .dram_we_n(we_n),
        .busy(busy), .sleep_ack(sleep_ack), .wake_done(wake_done), .refresh_now(refresh_now)
    );

    task automatic chk(input string req, input int act, input int exp);
        vec++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic idle_state(input string req);
        chk({req, " cke"}, int'(cke), 1);
        chk({req, " pins"}, int'(pins), 7);
        chk({req, " busy"}, int'(busy), 0);
        chk({req, " ack"}, int'(sleep_ack), 0);
        chk({req, " done"}, int'(wake_done), 0);
        chk({req, " refresh"}, int'(refresh_now), 0);
    endtask

    // One full entry/stay/exit cycle with the given delays.
    task automatic run(input int bi, input int wk, input int cs);
        int k, a, exp_low;
        sleep_req  = 1'b1;
        banks_idle = 1'b0;
        for (int i = 0; i < bi; i++) begin
            @(negedge clk);
            chk("R2 stall cke", int'(cke), 1);
            chk("R8 stall busy", int'(busy), 0);
        end
        banks_idle = 1'b1;
        @(negedge clk);
        chk("R3 entry cke", int'(cke), 0);
        chk("R3 entry pins", int'(pins), 1);
        chk("R3 entry ack", int'(sleep_ack), 1);
        chk("R8 entry busy", int'(busy), 1);
        banks_idle = 1'b0;
        a = ((wk > MS) ? wk : MS) + 1;
        exp_low = ((a > wk + cs) ? a : wk + cs) + 1;
        k = 0;
        while (1) begin
            if (k == wk) begin
                wake_req  = 1'b1;
                sleep_req = 1'b0;
            end
            if (k == wk + cs) clk_stable = 1'b1;
            @(negedge clk);
            k++;
            if (cke || k > 60) break;
            chk("R3 low pins", int'(pins), 7);
            chk("R3 low ack", int'(sleep_ack), 1);
            chk("R8 low busy", int'(busy), 1);
        end
        chk("R4 R5 low length", k, exp_low);
        for (int h = 0; h <= XE; h++) begin
            chk("R6 exit pins", int'(pins), 7);
            chk("R6 exit cke", int'(cke), 1);
            chk("R7 done", int'(wake_done), (h == XE) ? 1 : 0);
            chk("R7 refresh", int'(refresh_now), (h == XE) ? 1 : 0);
            chk("R8 exit busy", int'(busy), 1);
            if (h == XE) begin
                wake_req   = 1'b0;
                clk_stable = 1'b0;
            end
            @(negedge clk);
        end
        idle_state("R7 back idle");
    endtask

    initial begin
        rst_n = 1'b0; sleep_req = 1'b0; banks_idle = 1'b0;
        wake_req = 1'b0; clk_stable = 1'b0;
        repeat (3) @(negedge clk);
        idle_state("R1 in reset");
        rst_n = 1'b1;
        @(negedge clk);
        idle_state("R1 after reset");

        // A pending wake blocks entry even with idle banks.
        sleep_req = 1'b1; banks_idle = 1'b1; wake_req = 1'b1;
        repeat (4) begin
            @(negedge clk);
            chk("R2 wake blocks cke", int'(cke), 1);
            chk("R2 wake blocks busy", int'(busy), 0);
        end
        sleep_req = 1'b0; banks_idle = 1'b0; wake_req = 1'b0;
        @(negedge clk);
        idle_state("R2 no entry");

        for (int bi = 0; bi < 3; bi++)
            for (int wk = 0; wk < 8; wk++)
                for (int cs = 0; cs < 4; cs++)
                    run(bi, wk, cs);

        if (!finished) begin
            finished = 1;
            $display("== %0d vectors applied, %0d miscompares ==", vec, bad);
            $finish;
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            bad++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("== %0d vectors applied, %0d miscompares ==", vec, bad);
            $finish;
        end
    end

endmodule